// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Digit Hold

This block turns a four-bit binary-coded decimal digit into seven active-high segment drives for a common-cathode display. A store control freezes the shown digit, so the display stays the same while the source bus keeps changing. Two active-low overrides act on the output side. Lamp test lights every segment. Blanking turns every segment off. Lamp test wins over blanking, and blanking wins over the decoded digit.

The hold is a clocked register, not a transparent latch. While store is low, the register loads the input code on every clock. While store is high, it keeps its value. The decoded pattern goes through a registered override stage. As a result, a new code reaches the segments two rising edges after it is applied, and an override reaches them one edge after it is applied. A code above nine gives a dark display instead of a hexadecimal glyph.

Top module: `segdisp_decoder`

## Requirements
- R1: `seg_o` bit 0 drives segment a, and bits 1 to 6 drive b, c, d, e, f and g in that order. A 1 lights the segment.
- R2: With both overrides inactive, codes 0 to 9 show these patterns: 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D (top bar lit), 7=7'h07, 8=7'h7F, 9=7'h6F (top bar and bottom bar lit).
- R3: While `store_i` is low, the hold register loads `bcd_i` on every rising edge. The segments show the new code after the second rising edge.
- R4: While `store_i` is high, the held code does not change, and changes on `bcd_i` have no effect on `seg_o`.
- R5: With both overrides inactive, codes 10 to 15 give `seg_o` = 7'h00.
- R6: When `lamp_test_n_i` is low, `seg_o` is 7'h7F after the next rising edge. This holds for any value of blank, store and code.
- R7: When `blank_n_i` is low and `lamp_test_n_i` is high, `seg_o` is 7'h00 after the next rising edge.
- R8: While `rst_i` is high at a rising edge, `seg_o` becomes 7'h00 and the held code becomes 0.
- R9: Lamp test and blanking do not disturb a stored digit. After both return high, the stored digit shows again with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bcd_i | input | 4 | BCD digit in |
| store_i | input | 1 | High holds the current digit |
| lamp_test_n_i | input | 1 | Active-low lamp test |
| blank_n_i | input | 1 | Active-low blanking |
| seg_o | output | 7 | Segment drives a..g, active high |

## Verification
Four behaviours are checked by assertions on every cycle:
- The hold register loads the input whenever store is low.
- The hold register stays frozen whenever store is high.
- Lamp test forces all segments on one edge later.
- Blanking with lamp test inactive forces all segments off one edge later.

Two things only the bench scenarios can show. The first is that the glyph table is correct: every code is checked under each of the four lamp-test and blank combinations. The second is that a stored digit survives input changes and override pulses and then reappears unchanged.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int SEG_W  = 7;
  localparam int CODE_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_ALL_ON  = '1;
  localparam seg_t SEG_ALL_OFF = '0;
endpackage

// File: rtl/digit_hold.sv
module digit_hold #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         store_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)         q_o <= '0;
    else if (!store_i) q_o <= d_i;
  end

  // R3
  hold_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !store_i |=> q_o == $past(d_i));

  // R4
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    store_i |=> $stable(q_o));
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import segdisp_pkg::*;
#(
  parameter int W        = 4,
  parameter int MAX_CODE = 9
) (
  input  logic [W-1:0] code_i,
  output seg_t         pat_o
);
  // bit order {g,f,e,d,c,b,a}
  always_comb begin
    if (int'(code_i) > MAX_CODE) begin
      pat_o = SEG_ALL_OFF;
    end else begin
      case (int'(code_i))
        0:       pat_o = 7'b0111111;
        1:       pat_o = 7'b0000110;
        2:       pat_o = 7'b1011011;
        3:       pat_o = 7'b1001111;
        4:       pat_o = 7'b1100110;
        5:       pat_o = 7'b1101101;
        6:       pat_o = 7'b1111101;
        7:       pat_o = 7'b0000111;
        8:       pat_o = 7'b1111111;
        9:       pat_o = 7'b1101111;
        default: pat_o = SEG_ALL_OFF;
      endcase
    end
  end
endmodule

// File: rtl/seg_override.sv
module seg_override
  import segdisp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic lamp_test_n_i,
  input  logic blank_n_i,
  input  seg_t pat_i,
  output seg_t seg_o
);
  seg_t seg_d;

  always_comb begin
    if (!lamp_test_n_i)  seg_d = SEG_ALL_ON;
    else if (!blank_n_i) seg_d = SEG_ALL_OFF;
    else                 seg_d = pat_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) seg_o <= SEG_ALL_OFF;
    else       seg_o <= seg_d;
  end

  // R6
  lamp_all_on_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !lamp_test_n_i |=> seg_o == SEG_ALL_ON);

  // R7
  blank_all_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (lamp_test_n_i && !blank_n_i) |=> seg_o == SEG_ALL_OFF);
endmodule

// File: rtl/segdisp_decoder.sv
module segdisp_decoder
  import segdisp_pkg::*;
#(
  parameter int MAX_CODE = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] bcd_i,
  input  logic              store_i,
  input  logic              lamp_test_n_i,
  input  logic              blank_n_i,
  output logic [SEG_W-1:0]  seg_o
);
  logic [CODE_W-1:0] held_code;
  seg_t              raw_pat;

  digit_hold #(.W(CODE_W)) hold_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .store_i (store_i),
    .d_i     (bcd_i),
    .q_o     (held_code)
  );

  seg_decode #(.W(CODE_W), .MAX_CODE(MAX_CODE)) dec_i (
    .code_i (held_code),
    .pat_o  (raw_pat)
  );

  seg_override ovr_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .lamp_test_n_i (lamp_test_n_i),
    .blank_n_i     (blank_n_i),
    .pat_i         (raw_pat),
    .seg_o         (seg_o)
  );
endmodule

// File: tb/segdisp_decoder_tb_top.sv
module segdisp_decoder_tb_top;
  typedef struct {
    logic [6:0] exp;
    string      tag;
  } item_t;

  logic       clk = 0;
  logic       rst = 1;
  logic [3:0] bcd = 0;
  logic       store = 0;
  logic       lt_n = 1;
  logic       bk_n = 1;
  logic [6:0] seg;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  item_t sb[$];

  always #4 clk = ~clk;

  segdisp_decoder dut_i (
    .clk_i         (clk),
    .rst_i         (rst),
    .bcd_i         (bcd),
    .store_i       (store),
    .lamp_test_n_i (lt_n),
    .blank_n_i     (bk_n),
    .seg_o         (seg)
  );

  function automatic logic [6:0] glyph(input int c);
    case (c)
      0: return 7'h3F;
      1: return 7'h06;
      2: return 7'h5B;
      3: return 7'h4F;
      4: return 7'h66;
      5: return 7'h6D;
      6: return 7'h7D;
      7: return 7'h07;
      8: return 7'h7F;
      9: return 7'h6F;
      default: return 7'h00; // R5
    endcase
  endfunction

  task automatic drive(input int c, input bit st, input bit lt, input bit bk,
                       input logic [6:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bcd = 4'(c); store = st; lt_n = lt; bk_n = bk;
    repeat (2) @(posedge clk);
    #1;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (seg !== it.exp) begin
        n_fail++;
        $display("FAIL %s: seg=%h expected=%h", it.tag, seg, it.exp);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if (seg !== 7'h00) begin
      n_fail++;
      $display("FAIL R8: seg=%h expected=00", seg);
    end
    rst = 0;

    // R1 R2 R5 R6 R7: every code under each override combination
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 4; m++) begin
        bit lt = m[1];
        bit bk = m[0];
        logic [6:0] e;
        if (!lt)      e = 7'h7F;  // R6
        else if (!bk) e = 7'h00;  // R7
        else          e = glyph(c); // R2 / R5
        drive(c, 0, lt, bk, e, "R2_R5_R6_R7 code/override");
      end
    end

    // R3: follow when store low
    drive(3, 0, 1, 1, 7'h4F, "R3 load 3");
    // R4: store high freezes digit while inputs change
    drive(3, 1, 1, 1, 7'h4F, "R4 store 3");
    drive(7, 1, 1, 1, 7'h4F, "R4 input 7 ignored");
    drive(12, 1, 1, 1, 7'h4F, "R4 input 12 ignored");
    drive(8, 1, 1, 1, 7'h4F, "R4 input 8 ignored");
    // R6 R7 while stored, then R9 recovery
    drive(5, 1, 0, 1, 7'h7F, "R6 lamp during store");
    drive(5, 1, 1, 0, 7'h00, "R7 blank during store");
    drive(6, 1, 0, 0, 7'h7F, "R6 lamp beats blank");
    drive(9, 1, 1, 1, 7'h4F, "R9 stored digit returns");
    // R3: release store, input taken again
    drive(9, 0, 1, 1, 7'h6F, "R3 release to 9");
    drive(6, 0, 1, 1, 7'h7D, "R3 follow 6");
    drive(11, 0, 1, 1, 7'h00, "R5 follow 11");
    // R8: reset clears held digit
    drive(2, 1, 1, 1, 7'h00, "R5 store 11 hold");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    drive(4, 1, 1, 1, 7'h3F, "R8 held code cleared to 0");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule